// File: doc/BRIEF.md
# Regulator Startup Supervisor

This block watches one regulator channel from the moment its enable request goes high until the output is in regulation. First it holds the channel in a soft-start phase. It stays there until a comparator reports that the output has risen above the low startup threshold. The channel then moves to a slew-controlled ramp, using a 3-bit rate code captured on entry. When the power-good comparator reports, the ramp is complete. If the low threshold is not reached within one millisecond, the block forces the regulator off and records a short-circuit event.

Two sticky interrupt flags record the short-circuit timeout and the power-good arrival. Each flag stays set until a write-one-to-clear pulse on its own bit. The interrupt request line combines the flags, and a mask input keeps the power-good flag from raising it. Dropping the enable request returns the channel to its off state from any state. This is the only way out of the forced-off state.

Top module: `reg_start_supervisor`

## Requirements
- R1: After reset, `slew_active`, `force_off`, `short_flag`, `pg_flag`, `irq` and `slew_rate` are all 0.
- R2: With `en_req` high in the off state, the block enters soft-start one clock later. Soft-start drives `slew_active` and `force_off` low and lasts until `above_low` is seen high or the timeout fires.
- R3: `above_low` high during soft-start gives `slew_active` high one clock later. `slew_rate` then carries the `slew_cfg` value sampled at that edge. The value is held while `slew_active` stays high, and `slew_rate` is 0 whenever `slew_active` is low.
- R4: The timeout fires when, in soft-start, the second `ms_tick` pulse arrives without `above_low`. One clock later, `force_off` and `short_flag` are high and `slew_active` is low. If `above_low` is high in the same cycle, the ramp wins and there is no timeout.
- R5: `pg_in` high while ramping sets `pg_flag` and ends the ramp: `slew_active` goes low one clock later, and the block remains in the good state.
- R6: `force_off` stays high while `en_req` stays high. `en_req` low in any state gives `slew_active` = 0 and `force_off` = 0 one clock later, and the block is back in the off state.
- R7: Flags are sticky. Bit 0 of `clr_w1c` clears `short_flag` and bit 1 clears `pg_flag`, one clock later. A set event in the same cycle as its clear leaves the flag set.
- R8: `irq` equals `short_flag` OR (`pg_flag` AND NOT `pg_mask`). It is combinational in `pg_mask`, so a mask change shows on `irq` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Channel enable request |
| above_low | input | 1 | Output above the low startup threshold |
| pg_in | input | 1 | Output at the power-good threshold |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pg_mask | input | 1 | Keeps `pg_flag` off the interrupt line |
| slew_cfg | input | 3 | Ramp rate code |
| clr_w1c | input | 2 | Write-one-to-clear: bit 0 short, bit 1 power-good |
| slew_active | output | 1 | Slew-controlled ramp in progress |
| slew_rate | output | 3 | Rate code captured at ramp entry, 0 when not ramping |
| force_off | output | 1 | Regulator forced off after a timeout |
| short_flag | output | 1 | Sticky startup-timeout flag |
| pg_flag | output | 1 | Sticky power-good flag |
| irq | output | 1 | Interrupt request |

## Verification
Every state output and every flag is registered and settles one clock after the edge that samples the input causing it. `irq` is the only exception: it follows `pg_mask` and the flags with no delay. The bench changes inputs on the falling edge and advances a reference model at the rising edge using the held inputs. It then compares every output at the next falling edge, so each result is checked in the cycle it becomes due. Mask changes are checked a short delay after the drive, with no intervening clock edge.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_SOFT  = 3'd1,
    ST_RAMP  = 3'd2,
    ST_GOOD  = 3'd3,
    ST_FAULT = 3'd4
  } sup_state_e;

  localparam int FLAG_SHORT = 0;
  localparam int FLAG_PG    = 1;
  localparam int NUM_FLAGS  = 2;

  // Interrupt request from the flag vector and the power-good mask
  function automatic logic irq_of(logic [NUM_FLAGS-1:0] flags, logic pg_mask);
    return flags[FLAG_SHORT] | (flags[FLAG_PG] & ~pg_mask);
  endfunction

  // Sticky flag next value: set beats clear
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/rss_tick_timer.sv
module rss_tick_timer #(
  parameter int TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  assign expire = arm && tick && (cnt_q == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!arm || expire) cnt_q <= '0;
    else if (tick)          cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(TICKS)); // R4
  AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> cnt_q == '0); // R4
endmodule

// File: rtl/rss_flags.sv
module rss_flags
  import rss_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_ev,
  input  logic [NUM_FLAGS-1:0] clr_w1c,
  input  logic                 pg_mask,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= flag_next(flags[g], set_ev[g], clr_w1c[g]);
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flags[g] && !clr_w1c[g] |=> flags[g]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[g] |=> flags[g]); // R7
  end

  assign irq = irq_of(flags, pg_mask);

  AST_MASK_BLOCKS_PG: assert property (@(posedge clk) disable iff (!rst_n)
    pg_mask && !flags[FLAG_SHORT] |-> !irq); // R8
endmodule

// File: rtl/rss_fsm.sv
module rss_fsm
  import rss_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              above_low,
  input  logic              pg_in,
  input  logic              expire,
  input  logic [RATE_W-1:0] slew_cfg,
  output logic              in_soft,
  output logic              ev_timeout,
  output logic              ev_pg_reach,
  output logic              slew_active,
  output logic              force_off,
  output logic [RATE_W-1:0] slew_rate
);
  sup_state_e        st_q, st_d;
  logic [RATE_W-1:0] rate_q;
  logic              ev_ramp_entry;

  assign in_soft       = (st_q == ST_SOFT);
  assign ev_ramp_entry = en_req && in_soft && above_low;
  assign ev_timeout    = en_req && in_soft && !above_low && expire;
  assign ev_pg_reach   = en_req && (st_q == ST_RAMP) && pg_in;

  always_comb begin
    st_d = st_q;
    if (!en_req) st_d = ST_OFF;
    else begin
      unique case (st_q)
        ST_OFF:   st_d = ST_SOFT;
        ST_SOFT:  if (ev_ramp_entry) st_d = ST_RAMP;
                  else if (ev_timeout) st_d = ST_FAULT;
        ST_RAMP:  if (ev_pg_reach) st_d = ST_GOOD;
        ST_GOOD:  st_d = ST_GOOD;
        ST_FAULT: st_d = ST_FAULT;
        default:  st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      rate_q <= '0;
    end else begin
      st_q <= st_d;
      if (ev_ramp_entry) rate_q <= slew_cfg;
    end
  end

  assign slew_active = (st_q == ST_RAMP);
  assign force_off   = (st_q == ST_FAULT);
  assign slew_rate   = slew_active ? rate_q : '0;

  AST_DROP_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> !slew_active && !force_off); // R6
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    force_off && en_req |=> force_off); // R6
  AST_TIMEOUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> force_off && !slew_active); // R4
  AST_RAMP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ramp_entry |=> slew_active && slew_rate == $past(slew_cfg)); // R3
  AST_RATE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    slew_active && $past(slew_active) |-> $stable(slew_rate)); // R3
  AST_PG_ENDS_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pg_reach |=> !slew_active); // R5
endmodule

// File: rtl/reg_start_supervisor.sv
module reg_start_supervisor
  import rss_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 2,
  parameter int RATE_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              above_low,
  input  logic              pg_in,
  input  logic              ms_tick,
  input  logic              pg_mask,
  input  logic [RATE_W-1:0] slew_cfg,
  input  logic [1:0]        clr_w1c,
  output logic              slew_active,
  output logic [RATE_W-1:0] slew_rate,
  output logic              force_off,
  output logic              short_flag,
  output logic              pg_flag,
  output logic              irq
);
  logic                 in_soft;
  logic                 expire;
  logic                 ev_timeout;
  logic                 ev_pg_reach;
  logic [NUM_FLAGS-1:0] set_ev;
  logic [NUM_FLAGS-1:0] flags;

  rss_tick_timer #(.TICKS(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(in_soft), .tick(ms_tick), .expire(expire)
  );

  rss_fsm #(.RATE_W(RATE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .above_low(above_low),
    .pg_in(pg_in), .expire(expire), .slew_cfg(slew_cfg), .in_soft(in_soft),
    .ev_timeout(ev_timeout), .ev_pg_reach(ev_pg_reach),
    .slew_active(slew_active), .force_off(force_off), .slew_rate(slew_rate)
  );

  always_comb begin
    set_ev             = '0;
    set_ev[FLAG_SHORT] = ev_timeout;
    set_ev[FLAG_PG]    = ev_pg_reach;
  end

  rss_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_w1c(clr_w1c),
    .pg_mask(pg_mask), .flags(flags), .irq(irq)
  );

  assign short_flag = flags[FLAG_SHORT];
  assign pg_flag    = flags[FLAG_PG];

  AST_PG_FROM_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_flag) |-> $past(slew_active)); // R5
  AST_SHORT_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_flag) |-> force_off); // R4
  AST_EXCLUSIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slew_active, force_off})); // R6
endmodule

// File: tb/tb_reg_start_supervisor.sv
module tb_reg_start_supervisor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_req = 0, above_low = 0, pg_in = 0, ms_tick = 0, pg_mask = 0;
  logic [2:0] slew_cfg = 0;
  logic [1:0] clr_w1c = 0;
  logic       slew_active, force_off, short_flag, pg_flag, irq;
  logic [2:0] slew_rate;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // reference model: 0 off, 1 soft, 2 ramp, 3 good, 4 fault
  int         m_st = 0, m_cnt = 0;
  logic       m_s = 0, m_p = 0;
  logic [2:0] m_rate = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_start_supervisor dut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .above_low(above_low),
    .pg_in(pg_in), .ms_tick(ms_tick), .pg_mask(pg_mask), .slew_cfg(slew_cfg),
    .clr_w1c(clr_w1c), .slew_active(slew_active), .slew_rate(slew_rate),
    .force_off(force_off), .short_flag(short_flag), .pg_flag(pg_flag), .irq(irq)
  );

  function automatic logic exp_irq(logic s, logic p, logic m);
    return s | (p & ~m);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int  nst = m_st;
    bit  set_s = 0, set_p = 0;
    bit  expire = (m_st == 1) && ms_tick && (m_cnt == 1);
    if (!en_req) nst = 0;
    else case (m_st)
      0: nst = 1;
      1: if (above_low) begin nst = 2; m_rate = slew_cfg; end
         else if (expire) begin nst = 4; set_s = 1; end
      2: if (pg_in) begin nst = 3; set_p = 1; end
      default: ;
    endcase
    if (m_st != 1 || expire) m_cnt = 0;
    else if (ms_tick) m_cnt++;
    m_s = set_s | (m_s & ~clr_w1c[0]);
    m_p = set_p | (m_p & ~clr_w1c[1]);
    m_st = nst;
  endtask

  task automatic check_all();
    chk("R3 slew_active", slew_active, m_st == 2);
    chk("R3 slew_rate", slew_rate, (m_st == 2) ? m_rate : 0);
    chk("R4 force_off", force_off, m_st == 4);
    chk("R7 short_flag", short_flag, m_s);
    chk("R7 pg_flag", pg_flag, m_p);
    chk("R8 irq", irq, exp_irq(m_s, m_p, pg_mask));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic set_in(logic en, logic al, logic pg, logic tk, logic [1:0] clr);
    en_req = en; above_low = al; pg_in = pg; ms_tick = tk; clr_w1c = clr;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset slew_active", slew_active, 0);
    chk("R1 reset force_off", force_off, 0);
    chk("R1 reset flags", {short_flag, pg_flag, irq}, 0);
    chk("R1 reset slew_rate", slew_rate, 0);
    rst_n = 1'b1;

    // R2 enable enters soft-start, waits
    set_in(1, 0, 0, 0, 0); step();
    chk("R2 soft-start no force", force_off, 0);
    repeat (5) step();
    chk("R2 still waiting", slew_active, 0);
    // R4 timeout on second tick
    set_in(1, 0, 0, 1, 0); step();
    chk("R4 one tick no fault", force_off, 0);
    set_in(1, 0, 0, 0, 0); step();
    set_in(1, 0, 0, 1, 0); step();
    chk("R4 second tick fault", force_off, 1);
    chk("R4 short flag", short_flag, 1);
    set_in(1, 1, 1, 0, 0); repeat (3) step();
    chk("R6 fault holds", force_off, 1);
    // R8 mask does not hide short
    pg_mask = 1; #1; chk("R8 short ignores mask", irq, 1);
    // R6 drop enable
    set_in(0, 0, 0, 0, 0); step();
    chk("R6 off after drop", force_off, 0);
    // R7 clear short
    set_in(0, 0, 0, 0, 2'b01); step();
    chk("R7 short cleared", short_flag, 0);
    // R4 race: above_low with second tick
    set_in(1, 0, 0, 0, 0); step();
    set_in(1, 0, 0, 1, 0); step();
    slew_cfg = 3'd5;
    set_in(1, 1, 0, 1, 0); step();
    chk("R4 ramp wins race", slew_active, 1);
    chk("R3 rate captured", slew_rate, 5);
    slew_cfg = 3'd2; set_in(1, 0, 0, 0, 0); step();
    chk("R3 rate held", slew_rate, 5);
    // R5 + R7 set beats clear, R8 mask
    set_in(1, 0, 1, 0, 2'b10); step();
    chk("R5 pg flag", pg_flag, 1);
    chk("R5 ramp ends", slew_active, 0);
    chk("R8 masked pg", irq, 0);
    pg_mask = 0; #1; chk("R8 unmasked pg", irq, 1);
    set_in(0, 0, 0, 0, 2'b10); step();
    chk("R7 pg cleared", pg_flag, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      en_req    = ($urandom % 20) != 0;
      above_low = ($urandom % 12) == 0;
      pg_in     = ($urandom % 6) == 0;
      ms_tick   = ($urandom % 8) == 0;
      pg_mask   = ($urandom % 3) == 0;
      slew_cfg  = 3'($urandom);
      clr_w1c   = (($urandom % 10) == 0) ? 2'($urandom) : 2'b00;
      step();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule